// File: doc/BRIEF.md
# Virtual-Channel Router Input Port with One-Hop-Ahead XY Routing

This block is a single input port of a two-dimensional mesh router. Each arriving 32-bit flit comes with a virtual-channel number. The flit is written into the FIFO of that virtual channel. Head flits already carry the output port that this router must use. While a head flit is written, the port also works out the output port the packet will need at the *next* router. It uses dimension-order routing: X first, then Y, then local. That result is written back into the head flit's route field, so the flit leaves ready for the downstream router.

For each virtual channel the port shows the switch allocator the flit at the front of the FIFO. It also shows the output port that flit needs at this router. Wormhole packet state is kept per channel: body and tail flits use the port that their head flit reserved. When the switch grants a channel, the front flit is removed. A credit for that channel then goes back upstream.

Flit layout:
- bits [31:30]: flit type.
- bits [29:27]: destination X.
- bits [26:24]: destination Y.
- bits [23:21]: route field.
- bits [20:0]: payload.

Output-port codes:
- local = 0
- north = 1 (Y+1)
- south = 2 (Y-1)
- east = 3 (X+1)
- west = 4 (X-1)

This router's coordinates are parameters.

Top module: `vc_input_port`

## Requirements
- R1: After reset, no channel shows a flit, no channel is full, no channel is busy and `credit_valid` is low.
- R2: A flit written with `in_valid` and `in_vc`=v is at the front of channel v on the next cycle. Each channel hands out its flits in arrival order.
- R3: `vc_full[v]` is high while channel v holds DEPTH flits. A write to a full channel is dropped, so a full channel never hands out more than DEPTH flits.
- R4: For a flit of type head (00) or head-tail (11) at the front of a channel, `vc_port` equals that flit's bits [23:21]. For body (01) and tail (10) flits, `vc_port` equals the port taken from the most recently dequeued head of that channel.
- R5: For head and head-tail flits, the outgoing flit's bits [23:21] hold the XY route at the next router, and all other bits are unchanged. The next router's coordinates are this router's coordinates stepped one hop in the direction of the current port. At that router: if destination X is greater, the route is east; if smaller, west; otherwise, if destination Y is greater, north; if smaller, south; otherwise local. If the current port is local, the field becomes local. Body and tail flits pass through unchanged.
- R6: `vc_busy[v]` is set when a head (00) flit leaves channel v and cleared when a tail (10) flit leaves. A head-tail (11) flit leaves it idle.
- R7: The cycle after a flit leaves channel v, `credit_valid` is high for one cycle with `credit_vc`=v.
- R8: A grant to an empty channel removes nothing and produces no credit.
- R9: Traffic on one channel does not change the valid, full or busy state of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit strobe |
| in_vc | input | VCW | Channel the incoming flit belongs to |
| in_flit | input | 32 | Incoming flit |
| sw_grant | input | NUM_VC | Switch grant per channel, at most one bit set |
| vc_valid | output | NUM_VC | Channel has a flit at its front |
| vc_full | output | NUM_VC | Channel holds DEPTH flits |
| vc_busy | output | NUM_VC | Channel is inside a packet |
| vc_flit | output | NUM_VC*32 | Front flit of each channel, with the route rewritten for heads |
| vc_port | output | NUM_VC*3 | Output port at this router for each front flit |
| credit_valid | output | 1 | Credit pulse to upstream |
| credit_vc | output | VCW | Channel the credit belongs to |

## Verification
The bench checks the lookahead result in every direction. This includes hops that land exactly on the destination column or row. A design that routed Y before X, or that stepped from the wrong coordinate, would put the wrong code in the route field. The bench overfills one channel and then drains it while the other channel stays quiet. A FIFO that accepted a write while full would hand out more than eight flits or lose the order.

A full wormhole packet is sent whose body flit carries a misleading value in its route bits. A design that decoded body flits as heads would report that value as the port, not the held port. Grants to an empty channel must produce no credit.

// File: rtl/vcip_pkg.sv
package vcip_pkg;
  localparam int FLIT_W = 32;
  localparam int PORT_W = 3;
  localparam int TYPE_LSB = 30;
  localparam int DX_LSB = 27;
  localparam int DY_LSB = 24;
  localparam int RT_LSB = 21;

  localparam logic [1:0] FT_HEAD = 2'b00;
  localparam logic [1:0] FT_BODY = 2'b01;
  localparam logic [1:0] FT_TAIL = 2'b10;
  localparam logic [1:0] FT_SOLO = 2'b11;

  localparam logic [2:0] P_LOCAL = 3'd0;
  localparam logic [2:0] P_NORTH = 3'd1;
  localparam logic [2:0] P_SOUTH = 3'd2;
  localparam logic [2:0] P_EAST  = 3'd3;
  localparam logic [2:0] P_WEST  = 3'd4;

  // Dimension-order decision at a router sitting at (cx, cy).
  function automatic logic [2:0] xy_dir(input logic [2:0] cx, input logic [2:0] cy,
                                        input logic [2:0] dx, input logic [2:0] dy);
    if (dx > cx) return P_EAST;
    if (dx < cx) return P_WEST;
    if (dy > cy) return P_NORTH;
    if (dy < cy) return P_SOUTH;
    return P_LOCAL;
  endfunction

  // Coordinates one hop away through the given port, packed {x, y}.
  function automatic logic [5:0] hop(input logic [2:0] cx, input logic [2:0] cy,
                                     input logic [2:0] port);
    case (port)
      P_EAST:  return {cx + 3'd1, cy};
      P_WEST:  return {cx - 3'd1, cy};
      P_NORTH: return {cx, cy + 3'd1};
      P_SOUTH: return {cx, cy - 3'd1};
      default: return {cx, cy};
    endcase
  endfunction

  function automatic logic is_head(input logic [1:0] t);
    return (t == FT_HEAD) || (t == FT_SOLO);
  endfunction
endpackage

// File: rtl/vcip_lookahead.sv
module vcip_lookahead
  import vcip_pkg::*;
#(
  parameter logic [2:0] MY_X = 3'd2,
  parameter logic [2:0] MY_Y = 3'd2
) (
  input  logic [FLIT_W-1:0] flit_in,
  output logic [PORT_W-1:0] cur_port,
  output logic [FLIT_W-1:0] flit_out
);
  logic [1:0] ftype;
  logic [2:0] dst_x, dst_y;
  logic [5:0] nxt_xy;
  logic [2:0] nxt_port;

  always_comb begin
    ftype    = flit_in[TYPE_LSB +: 2];
    dst_x    = flit_in[DX_LSB +: 3];
    dst_y    = flit_in[DY_LSB +: 3];
    cur_port = flit_in[RT_LSB +: PORT_W];
    nxt_xy   = hop(MY_X, MY_Y, cur_port);
    nxt_port = (cur_port == P_LOCAL) ? P_LOCAL : xy_dir(nxt_xy[5:3], nxt_xy[2:0], dst_x, dst_y);
    flit_out = flit_in;
    if (is_head(ftype)) flit_out[RT_LSB +: PORT_W] = nxt_port;
  end
endmodule

// File: rtl/vcip_fifo.sv
module vcip_fifo #(
  parameter int W     = 35,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CMAX);
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (wr_en && !rd_en) cnt <= cnt + 1'b1;
      else if (rd_en && !wr_en) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/vcip_vc_ctrl.sv
module vcip_vc_ctrl
  import vcip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deq,
  input  logic [1:0]        front_type,
  input  logic [PORT_W-1:0] front_port,
  output logic              busy,
  output logic [PORT_W-1:0] port_out
);
  logic [PORT_W-1:0] held_port;

  assign port_out = is_head(front_type) ? front_port : held_port;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      held_port <= P_LOCAL;
    end else if (deq) begin
      if (front_type == FT_HEAD) begin
        busy      <= 1'b1;
        held_port <= front_port;
      end else if (front_type == FT_TAIL) begin
        busy <= 1'b0;
      end else if (front_type == FT_SOLO) begin
        held_port <= front_port;
      end
    end
  end
endmodule

// File: rtl/vc_input_port.sv
module vc_input_port
  import vcip_pkg::*;
#(
  parameter int NUM_VC = 2,
  parameter int DEPTH  = 8,
  parameter logic [2:0] MY_X = 3'd2,
  parameter logic [2:0] MY_Y = 3'd2,
  localparam int VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [VCW-1:0]           in_vc,
  input  logic [FLIT_W-1:0]        in_flit,
  input  logic [NUM_VC-1:0]        sw_grant,
  output logic [NUM_VC-1:0]        vc_valid,
  output logic [NUM_VC-1:0]        vc_full,
  output logic [NUM_VC-1:0]        vc_busy,
  output logic [NUM_VC*FLIT_W-1:0] vc_flit,
  output logic [NUM_VC*PORT_W-1:0] vc_port,
  output logic                     credit_valid,
  output logic [VCW-1:0]           credit_vc
);
  localparam int EW = FLIT_W + PORT_W;

  logic [PORT_W-1:0] la_port;
  logic [FLIT_W-1:0] la_flit;
  logic [NUM_VC-1:0] wr_fire, deq_fire, empty_w;
  logic [VCW-1:0]    deq_idx;

  vcip_lookahead #(.MY_X(MY_X), .MY_Y(MY_Y)) u_la (
    .flit_in(in_flit), .cur_port(la_port), .flit_out(la_flit)
  );

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [EW-1:0] front;

    assign wr_fire[v]  = in_valid && (in_vc == VCW'(v)) && !vc_full[v];
    assign vc_valid[v] = !empty_w[v];
    assign deq_fire[v] = sw_grant[v] && vc_valid[v];

    vcip_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_fire[v]), .wr_data({la_port, la_flit}),
      .rd_en(deq_fire[v]), .rd_data(front),
      .empty(empty_w[v]), .full(vc_full[v])
    );

    assign vc_flit[v*FLIT_W +: FLIT_W] = front[FLIT_W-1:0];

    vcip_vc_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .deq(deq_fire[v]),
      .front_type(front[TYPE_LSB +: 2]),
      .front_port(front[FLIT_W +: PORT_W]),
      .busy(vc_busy[v]),
      .port_out(vc_port[v*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    deq_idx = '0;
    for (int v = NUM_VC - 1; v >= 0; v--) begin
      if (deq_fire[v]) deq_idx = VCW'(v);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_valid <= 1'b0;
      credit_vc    <= '0;
    end else begin
      credit_valid <= |deq_fire;
      credit_vc    <= deq_idx;
    end
  end
endmodule

// File: rtl/vcip_checker.sv
module vcip_checker #(
  parameter int NUM_VC = 2,
  parameter int VCW    = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_VC-1:0] wr_fire,
  input logic [NUM_VC-1:0] deq_fire,
  input logic [NUM_VC-1:0] vc_full,
  input logic [NUM_VC-1:0] vc_valid,
  input logic [NUM_VC-1:0] vc_busy,
  input logic              credit_valid,
  input logic [VCW-1:0]    credit_vc
);
  logic [NUM_VC-1:0] prev_deq;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_deq <= '0;
    else        prev_deq <= deq_fire;
  end

  // R7: every dequeue is followed by a credit
  a_r7_credit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|deq_fire) |=> credit_valid);

  // R7: the credit names the channel that was dequeued
  a_r7_credit_vc: assert property (@(posedge clk) disable iff (!rst_n)
    credit_valid |-> prev_deq[credit_vc]);

  // R8: no dequeue, no credit
  a_r8_no_stray_credit: assert property (@(posedge clk) disable iff (!rst_n)
    !(|deq_fire) |=> !credit_valid);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
    // R2: a write makes the channel visible next cycle
    a_r2_visible: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire[v] |=> vc_valid[v]);

    // R3: a full channel without a dequeue stays full
    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (vc_full[v] && !deq_fire[v]) |=> vc_full[v]);

    // R6: busy rises only after a dequeue from that channel
    a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vc_busy[v]) |-> prev_deq[v]);
  end
endmodule

bind vc_input_port vcip_checker #(.NUM_VC(NUM_VC), .VCW(VCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .deq_fire(deq_fire),
  .vc_full(vc_full), .vc_valid(vc_valid), .vc_busy(vc_busy),
  .credit_valid(credit_valid), .credit_vc(credit_vc)
);

// File: tb/vc_input_port_bench.sv
module vc_input_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [0:0] in_vc = '0;
  logic [31:0] in_flit = '0;
  logic [1:0] sw_grant = '0;
  logic [1:0] vc_valid, vc_full, vc_busy;
  logic [63:0] vc_flit;
  logic [5:0] vc_port;
  logic credit_valid;
  logic [0:0] credit_vc;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  vc_input_port #(.NUM_VC(2), .DEPTH(8), .MY_X(3'd2), .MY_Y(3'd2)) u_vc_input_port (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit),
    .sw_grant(sw_grant), .vc_valid(vc_valid), .vc_full(vc_full), .vc_busy(vc_busy),
    .vc_flit(vc_flit), .vc_port(vc_port), .credit_valid(credit_valid), .credit_vc(credit_vc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {flit, expected next-router route}; router at (2,2)
  localparam logic [34:0] VEC [10] = '{
    {2'b11, 3'd5, 3'd2, 3'd3, 21'h0A001, 3'd3},
    {2'b11, 3'd3, 3'd4, 3'd3, 21'h0A002, 3'd1},
    {2'b11, 3'd3, 3'd2, 3'd3, 21'h0A003, 3'd0},
    {2'b11, 3'd0, 3'd0, 3'd4, 21'h0A004, 3'd4},
    {2'b11, 3'd2, 3'd5, 3'd1, 21'h0A005, 3'd1},
    {2'b11, 3'd2, 3'd1, 3'd2, 21'h0A006, 3'd0},
    {2'b11, 3'd2, 3'd0, 3'd2, 21'h0A007, 3'd2},
    {2'b11, 3'd2, 3'd2, 3'd0, 21'h0A008, 3'd0},
    {2'b11, 3'd2, 3'd3, 3'd1, 21'h0A009, 3'd0},
    {2'b11, 3'd1, 3'd6, 3'd4, 21'h0A00A, 3'd1}
  };

  task automatic put(input logic vc, input logic [31:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_vc = vc; in_flit = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop(input int vc, input string req);
    sw_grant = '0; sw_grant[vc] = 1'b1;
    @(negedge clk);
    sw_grant = '0;
    check(req, {31'd0, credit_valid}, 32'd1);
    check(req, {31'd0, credit_vc}, vc);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] f;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {30'd0, vc_valid}, 0);
    check("R1 full", {30'd0, vc_full}, 0);
    check("R1 busy", {30'd0, vc_busy}, 0);
    check("R1 credit", {31'd0, credit_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5/R4 lookahead table on channel 0
    for (int i = 0; i < 10; i++) begin
      f = VEC[i][34:3];
      put(1'b0, f);
      check("R2 visible", {31'd0, vc_valid[0]}, 1);
      check("R4 head port", {29'd0, vc_port[2:0]}, {29'd0, f[23:21]});
      check("R5 next route", {29'd0, vc_flit[23:21]}, {29'd0, VEC[i][2:0]});
      check("R5 other bits", {vc_flit[31:24], 3'd0, vc_flit[20:0]}, {f[31:24], 3'd0, f[20:0]});
      pop(0, "R7 credit");
      check("R6 solo idle", {31'd0, vc_busy[0]}, 0);
    end
    @(negedge clk);
    check("R7 one pulse", {31'd0, credit_valid}, 0);

    // R8 grant to empty channel
    sw_grant = 2'b10;
    @(negedge clk);
    @(negedge clk);
    check("R8 no credit", {31'd0, credit_valid}, 0);
    sw_grant = '0;

    // R3/R2/R9 overfill channel 1 with body flits
    for (int i = 0; i < 10; i++) begin
      put(1'b1, {2'b01, 9'd0, 21'(i)});
    end
    check("R3 full", {31'd0, vc_full[1]}, 1);
    check("R9 other empty", {30'd0, vc_valid[0], vc_full[0]}, 0);
    for (int i = 0; i < 8; i++) begin
      check("R2 order", {11'd0, vc_flit[52:32]}, i);
      pop(1, "R7 credit vc1");
    end
    check("R3 dropped", {31'd0, vc_valid[1]}, 0);

    // R4/R6 wormhole packet on channel 0
    put(1'b0, {2'b00, 3'd5, 3'd2, 3'd3, 21'h1});
    put(1'b0, {2'b01, 3'd0, 3'd0, 3'd6, 21'h2});
    put(1'b0, {2'b10, 3'd0, 3'd0, 3'd1, 21'h3});
    check("R6 idle before", {31'd0, vc_busy[0]}, 0);
    check("R4 head", {29'd0, vc_port[2:0]}, 3);
    pop(0, "R7 head");
    check("R6 busy", {31'd0, vc_busy[0]}, 1);
    check("R4 body held", {29'd0, vc_port[2:0]}, 3);
    check("R5 body unchanged", {29'd0, vc_flit[23:21]}, 6);
    check("R9 vc1 idle", {31'd0, vc_busy[1]}, 0);
    pop(0, "R7 body");
    check("R4 tail held", {29'd0, vc_port[2:0]}, 3);
    pop(0, "R7 tail");
    check("R6 idle after tail", {31'd0, vc_busy[0]}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule